// File: doc/BRIEF.md
# E1 Receive Alignment Supervisor

This block sits behind an external E1 frame aligner. It watches the received bit stream after alignment and judges whether alignment still holds. The aligner marks the eight bits of timeslot 0 and says whether the current frame is an alignment-word frame or the alternate frame. The supervisor checks the alignment word and the bit 2 marker of the alternate word. It counts consecutive errors in each, and sends a one-cycle resync request to the aligner when the error limit is reached. Software can also force a resync through a control bit that acts on its rising edge. A separate counter tracks runs of zeros and raises a loss-of-signal flag after a selectable run length.

A loss-of-frame flag goes up with every resync request. It stays up until the aligner reports that alignment has been regained. All control inputs are sampled on the system clock. Received bits count only in cycles where the bit enable is high.

Top module: `e1_align_supervisor`

## Requirements
- R1: A rising edge on `ctl_resync` (sampled low, then high) gives exactly one `resync_req` pulse, one clock wide, in the cycle after the high sample. Holding `ctl_resync` high gives no further pulse; it must go low and rise again.
- R2: While `ctl_auto_off` is 1, alignment errors never cause `resync_req`; only R1 can. While it is 0, automatic requests are allowed.
- R3: Timeslot-0 bits arrive bit 1 first. In a frame with `fas_frame`=1, bits 2..8 must equal 0011011. When this word is wrong in three consecutive alignment-word frames, `resync_req` pulses.
- R4: In a frame with `fas_frame`=0, bit 2 of timeslot 0 must be 1. With `ctl_crit_nfas`=1, three consecutive wrong bits give `resync_req`. With `ctl_crit_nfas`=0, these errors have no effect.
- R5: With `ctl_los_long`=0, `rlos` rises after 255 consecutive received zeros and not after 254.
- R6: With `ctl_los_long`=1, `rlos` rises after 2048 consecutive received zeros and not after 2047.
- R7: `rlos` clears on the first received one. Once declared, it stays set through any further zeros.
- R8: A correctly received word clears its own consecutive-error count. Every resync request clears both counts.
- R9: `lof` is set together with each `resync_req`. It is cleared by a `realigned` pulse when no request occurs in the same cycle. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One received bit is valid this cycle |
| rx_bit | input | 1 | Received data bit |
| ts0_active | input | 1 | Current bit lies in timeslot 0 (high for its 8 bits) |
| fas_frame | input | 1 | Current frame carries the alignment word |
| realigned | input | 1 | Aligner reports alignment regained |
| ctl_resync | input | 1 | Manual resync, acts on its rising edge |
| ctl_auto_off | input | 1 | 1 = suppress automatic resync |
| ctl_crit_nfas | input | 1 | 1 = also count alternate-word bit 2 errors |
| ctl_los_long | input | 1 | 0 = 255-zero threshold, 1 = 2048-zero threshold |
| resync_req | output | 1 | One-cycle request for a new frame search |
| lof | output | 1 | Loss of frame |
| rlos | output | 1 | Receive loss of signal |

## Verification
A wrong error count shows as a resync pulse one word too early or too late. Either way, it appears two clocks after the last bit of the third bad timeslot 0, so it is seen within one frame pair. An edge detector that lost its past value shows as repeated or missing pulses while the manual bit is held. A zero counter that is off by one moves the rise of `rlos` by exactly one bit, so the bench looks at the 254th/255th and 2047th/2048th zeros.

// File: rtl/e1_sup_pkg.sv
// Package: shared constants of the E1 receive alignment supervisor.
// Assumes timeslot-0 bits arrive bit 1 first (MSB of the collected byte).
package e1_sup_pkg;
    localparam logic [6:0] FAS_WORD   = 7'b0011011;
    localparam int         ERR_LIMIT  = 3;
    localparam int         LOS_SHORT  = 255;
    localparam int         LOS_LONG   = 2048;
    localparam int         ZCNT_W     = $clog2(LOS_LONG + 1);
    localparam int         ECNT_W     = $clog2(ERR_LIMIT + 1);
endpackage

// File: rtl/e1_ts0_checker.sv
// Collects the eight bits of timeslot 0 and grades them.
// Assumes ts0_active stays high across exactly 8 enabled bits; the bit index
// restarts whenever ts0_active is low. Results appear one clock after bit 8.
module e1_ts0_checker
    import e1_sup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic ts0_active,
    input  logic fas_frame,
    output logic fas_done,
    output logic fas_bad,
    output logic nfas_done,
    output logic nfas_bad
);
    logic [6:0] shreg;
    logic [2:0] idx;
    logic [7:0] word;

    // Assemble the full byte including the bit arriving now.
    always_comb word = {shreg, rx_bit};

    // Shift in timeslot-0 bits and grade the byte after bit 8.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            idx       <= '0;
            fas_done  <= 1'b0;
            fas_bad   <= 1'b0;
            nfas_done <= 1'b0;
            nfas_bad  <= 1'b0;
        end else begin
            fas_done  <= 1'b0;
            nfas_done <= 1'b0;
            if (!ts0_active) begin
                idx <= '0;
            end else if (bit_en) begin
                shreg <= word[6:0];
                idx   <= idx + 3'd1;
                if (idx == 3'd7) begin
                    fas_done  <= fas_frame;
                    nfas_done <= !fas_frame;
                    fas_bad   <= (word[6:0] != FAS_WORD);
                    nfas_bad  <= !word[6];
                end
            end
        end
    end
endmodule

// File: rtl/e1_err_run.sv
// Counts consecutive bad results of one check and trips at LIMIT.
// Assumes check is a one-cycle pulse; trip is combinational on that pulse.
module e1_err_run #(
    parameter int LIMIT = 3,
    localparam int W    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic check,
    input  logic bad,
    input  logic clear,
    output logic trip
);
    logic [W-1:0] cnt;

    // Flag the result that completes the run of LIMIT errors.
    always_comb trip = enable && check && bad && (cnt == W'(LIMIT - 1));

    // Advance on errors, restart on good words, resyncs or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !enable) begin
            cnt <= '0;
        end else if (check) begin
            if (!bad || trip) cnt <= '0;
            else              cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/e1_zero_run.sv
// Loss-of-signal detector: counts received zeros, saturating at the threshold.
// Assumes the threshold select may change at any time; the flag follows the
// saturated count.
module e1_zero_run #(
    parameter int SHORT_RUN = 255,
    parameter int LONG_RUN  = 2048,
    localparam int W        = $clog2(LONG_RUN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic long_sel,
    output logic los
);
    logic [W-1:0] cnt;
    logic [W-1:0] limit;
    logic [W-1:0] next_cnt;

    // Pick the active threshold and the saturated next count.
    always_comb begin
        limit    = long_sel ? W'(LONG_RUN) : W'(SHORT_RUN);
        next_cnt = (cnt < limit) ? cnt + W'(1) : cnt;
    end

    // Track the zero run and declare or release loss of signal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            los <= 1'b0;
        end else if (bit_en) begin
            if (rx_bit) begin
                cnt <= '0;
                los <= 1'b0;
            end else begin
                cnt <= next_cnt;
                los <= (next_cnt >= limit);
            end
        end
    end
endmodule

// File: rtl/e1_resync_ctl.sv
// Merges the manual edge and automatic trips into the resync pulse and keeps
// the loss-of-frame flag. Assumes trips are single-cycle.
module e1_resync_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_resync,
    input  logic auto_off,
    input  logic auto_trip,
    input  logic realigned,
    output logic resync_req,
    output logic lof
);
    logic prev_resync;
    logic req_next;

    // Request on a manual rising edge or an allowed automatic trip.
    always_comb req_next = (ctl_resync && !prev_resync) || (auto_trip && !auto_off);

    // Register the request pulse, the edge history and the frame-loss flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_resync <= 1'b0;
            resync_req  <= 1'b0;
            lof         <= 1'b0;
        end else begin
            prev_resync <= ctl_resync;
            resync_req  <= req_next;
            if (req_next)       lof <= 1'b1;
            else if (realigned) lof <= 1'b0;
        end
    end
endmodule

// File: rtl/e1_align_supervisor.sv
// Top: E1 receive alignment supervisor. Grades timeslot 0 of aligned frames,
// counts consecutive errors, requests resync and reports loss of frame and
// loss of signal. Assumes the external aligner drives ts0_active/fas_frame.
module e1_align_supervisor
    import e1_sup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic ts0_active,
    input  logic fas_frame,
    input  logic realigned,
    input  logic ctl_resync,
    input  logic ctl_auto_off,
    input  logic ctl_crit_nfas,
    input  logic ctl_los_long,
    output logic resync_req,
    output logic lof,
    output logic rlos
);
    logic fas_done, fas_bad, nfas_done, nfas_bad;
    logic fas_trip, nfas_trip, auto_trip;

    e1_ts0_checker u_ts0 (
        .clk, .rst_n, .bit_en, .rx_bit, .ts0_active, .fas_frame,
        .fas_done, .fas_bad, .nfas_done, .nfas_bad
    );

    e1_err_run #(.LIMIT(ERR_LIMIT)) u_fas_run (
        .clk, .rst_n, .enable(1'b1), .check(fas_done), .bad(fas_bad),
        .clear(resync_req), .trip(fas_trip)
    );

    e1_err_run #(.LIMIT(ERR_LIMIT)) u_nfas_run (
        .clk, .rst_n, .enable(ctl_crit_nfas), .check(nfas_done), .bad(nfas_bad),
        .clear(resync_req), .trip(nfas_trip)
    );

    // Either counter reaching its limit is an automatic trip.
    always_comb auto_trip = fas_trip || nfas_trip;

    e1_resync_ctl u_ctl (
        .clk, .rst_n, .ctl_resync, .auto_off(ctl_auto_off), .auto_trip,
        .realigned, .resync_req, .lof
    );

    e1_zero_run #(.SHORT_RUN(LOS_SHORT), .LONG_RUN(LOS_LONG)) u_los (
        .clk, .rst_n, .bit_en, .rx_bit, .long_sel(ctl_los_long), .los(rlos)
    );
endmodule

// File: rtl/e1_align_supervisor_chk.sv
// Checker: port-level properties of the alignment supervisor, bound to the top.
module e1_align_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic rx_bit,
    input logic realigned,
    input logic ctl_resync,
    input logic ctl_auto_off,
    input logic resync_req,
    input logic lof,
    input logic rlos
);
    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        resync_req |=> !resync_req); // R1
    AST_NO_AUTO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_auto_off) && !$past(ctl_resync)) |-> !resync_req); // R2
    AST_RLOS_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rlos) |-> $past(bit_en && !rx_bit)); // R5
    AST_RLOS_CLEARS_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && rx_bit) |=> !rlos); // R7
    AST_LOF_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        resync_req |-> lof); // R9
    AST_LOF_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lof) |-> $past(realigned)); // R9
endmodule

bind e1_align_supervisor e1_align_supervisor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .realigned(realigned), .ctl_resync(ctl_resync), .ctl_auto_off(ctl_auto_off),
    .resync_req(resync_req), .lof(lof), .rlos(rlos)
);

// File: tb/e1_align_supervisor_test.sv
// Bench: vector table of frame-pair error patterns, then directed tests.
module e1_align_supervisor_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, rx_bit = 1'b0, ts0_active = 1'b0, fas_frame = 1'b0;
    logic realigned = 1'b0, ctl_resync = 1'b0, ctl_auto_off = 1'b0;
    logic ctl_crit_nfas = 1'b0, ctl_los_long = 1'b0;
    logic resync_req, lof, rlos;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 1'b0;

    localparam logic [7:0] FAS_OK  = 8'h9B;
    localparam logic [7:0] FAS_BAD = 8'h9A;
    localparam logic [7:0] NF_OK   = 8'hDF;
    localparam logic [7:0] NF_BAD  = 8'h9F;

    // [25:18] fas error mask, [17:10] alternate error mask, [9:6] pairs,
    // [5] crit, [4] auto_off, [3:0] expected pulses
    localparam int NV = 7;
    localparam logic [25:0] VECS [0:NV-1] = '{
        {8'b00000111, 8'b00000000, 4'd3, 1'b0, 1'b0, 4'd1},  // R3
        {8'b00000011, 8'b00000000, 4'd3, 1'b0, 1'b0, 4'd0},  // R3 two only
        {8'b00011011, 8'b00000000, 4'd5, 1'b0, 1'b0, 4'd0},  // R8 good breaks run
        {8'b00000000, 8'b00000111, 4'd3, 1'b0, 1'b0, 4'd0},  // R4 ignored
        {8'b00000000, 8'b00000111, 4'd3, 1'b1, 1'b0, 4'd1},  // R4 counted
        {8'b00000111, 8'b00000111, 4'd3, 1'b1, 1'b1, 4'd0},  // R2 suppressed
        {8'b00111111, 8'b00000000, 4'd6, 1'b0, 1'b0, 4'd2}   // R8 clear on resync
    };

    e1_align_supervisor uut (
        .clk, .rst_n, .bit_en, .rx_bit, .ts0_active, .fas_frame, .realigned,
        .ctl_resync, .ctl_auto_off, .ctl_crit_nfas, .ctl_los_long,
        .resync_req, .lof, .rlos
    );

    always #4 clk = ~clk;

    always @(negedge clk) if (rst_n && resync_req) pulses++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_ts0(input logic [7:0] b, input logic fas);
        for (int i = 0; i < 8; i++) begin
            bit_en = 1'b1; ts0_active = 1'b1; fas_frame = fas; rx_bit = b[7-i];
            tick();
        end
        ts0_active = 1'b0; rx_bit = 1'b1;
        for (int i = 0; i < 8; i++) tick();
    endtask

    task automatic send_pair(input bit fas_err, input bit nf_err);
        send_ts0(fas_err ? FAS_BAD : FAS_OK, 1'b1);
        send_ts0(nf_err ? NF_BAD : NF_OK, 1'b0);
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) begin
            bit_en = 1'b1; rx_bit = 1'b0; tick();
        end
    endtask

    task automatic one_bit();
        bit_en = 1'b1; rx_bit = 1'b1; tick();
    endtask

    initial begin
        repeat (3) tick();
        // reset state
        check(resync_req == 1'b0, "R1 reset", resync_req, 0);
        check(lof == 1'b0, "R9 reset", lof, 0);
        check(rlos == 1'b0, "R7 reset", rlos, 0);
        rst_n = 1'b1;
        tick();

        // vector table walk
        for (int v = 0; v < NV; v++) begin
            logic [25:0] e;
            e = VECS[v];
            ctl_crit_nfas = e[5]; ctl_auto_off = e[4];
            send_pair(1'b0, 1'b0);
            pulses = 0;
            for (int p = 0; p < int'(e[9:6]); p++) send_pair(e[18+p], e[10+p]);
            check(pulses == int'(e[3:0]), $sformatf("R3/R4/R2/R8 vector %0d", v),
                  pulses, int'(e[3:0]));
            if (e[3:0] != 0) begin
                check(lof == 1'b1, "R9 lof set", lof, 1);
                realigned = 1'b1; tick(); realigned = 1'b0; tick();
                check(lof == 1'b0, "R9 lof cleared", lof, 0);
            end
        end
        ctl_auto_off = 1'b0; ctl_crit_nfas = 1'b0;

        // R1 manual edge, held high
        pulses = 0;
        ctl_resync = 1'b1; tick();
        check(resync_req == 1'b1, "R1 pulse cycle", resync_req, 1);
        tick();
        check(resync_req == 1'b0, "R1 pulse width", resync_req, 0);
        repeat (20) tick();
        check(pulses == 1, "R1 held high", pulses, 1);
        ctl_resync = 1'b0; tick();
        ctl_resync = 1'b1; tick(); tick();
        check(pulses == 2, "R1 second edge", pulses, 2);
        ctl_resync = 1'b0;
        // R2 manual still works while auto is off
        ctl_auto_off = 1'b1; tick();
        ctl_resync = 1'b1; tick(); tick();
        check(pulses == 3, "R2 manual with auto off", pulses, 3);
        ctl_resync = 1'b0; ctl_auto_off = 1'b0;
        realigned = 1'b1; tick(); realigned = 1'b0; tick();

        // R5 short threshold
        ctl_los_long = 1'b0;
        one_bit();
        zeros(254);
        check(rlos == 1'b0, "R5 254 zeros", rlos, 0);
        zeros(1);
        check(rlos == 1'b1, "R5 255 zeros", rlos, 1);
        zeros(300);
        check(rlos == 1'b1, "R7 saturated", rlos, 1);
        one_bit();
        check(rlos == 1'b0, "R7 first one", rlos, 0);

        // R6 long threshold
        ctl_los_long = 1'b1;
        zeros(2047);
        check(rlos == 1'b0, "R6 2047 zeros", rlos, 0);
        zeros(1);
        check(rlos == 1'b1, "R6 2048 zeros", rlos, 1);
        one_bit();
        check(rlos == 1'b0, "R7 clear long", rlos, 0);

        // R8 counts cleared by manual resync
        ctl_los_long = 1'b0;
        send_pair(1'b0, 1'b0);
        send_pair(1'b1, 1'b0); send_pair(1'b1, 1'b0);
        ctl_resync = 1'b1; tick(); ctl_resync = 1'b0; tick();
        pulses = 0;
        send_pair(1'b1, 1'b0);
        check(pulses == 0, "R8 cleared by manual resync", pulses, 0);
        send_pair(1'b1, 1'b0); send_pair(1'b1, 1'b0);
        check(pulses == 1, "R3 third after restart", pulses, 1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule